// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block is the control unit of a small 8-bit processor. A 3-bit step counter walks through the steps of each instruction. At every step the block forms a 13-bit microcode address from the 8-bit opcode held in the instruction register, 2 condition-status bits and the step number. It then decodes that address through a built-in case table into a 20-bit control word. The word selects which internal register drives the internal bus and which one captures it. It also chooses the memory address source, steps the stack pointer and the program counter, commands the ALU, sets or clears the carry, requests a compare, and marks the last step of the instruction.

Step 0 is always the opcode fetch: memory at the PC goes into the instruction register and the PC increments. The opcode input is not yet meaningful during step 0, so the fetch word is forced there. The counter advances once per clock. On the clock after a step flagged as last, it returns to 0, which begins the next fetch. Entries that no instruction defines end the instruction at once, so an unknown opcode acts as a no-op. The status bits change the sequence only for the conditional jumps. The datapath registers, the ALU and memory are outside this block.

Top module: `ucode_sequencer`

## Requirements

- R1: While `rst_n` is low, `step` is 0 and the outputs show the fetch word. After `rst_n` rises at a falling clock edge, `step` stays 0 through the next two rising edges and reaches 1 on the third.
- R2: The step advances by one on each rising edge while `end_instr` is low. On the edge after a step with `end_instr` high, it returns to 0.
- R3: At step 0 the outputs are the fetch word, whatever the opcode and status are. The fetch word is: src=MEM(4), dst=IR(5), addr_sel=PC(0), pc_inc=1, and every other field 0. Register codes are: ACC 0, B 1, ALU 2, TEMP 3, MEM 4, IR 5, NONE 6, PCL 8, PCH 9, SPL A, SPH B, ADDL C, ADDH D, Y E, X F. Address select codes are: PC 0, address pointer 1, XY plus pointer 2, stack pointer 3.
- R4: Load immediate (opcode 0x10). Step 1 is MEM→ACC with addr PC, pc_inc and end.
- R5: Load absolute (0x11):
  - step 1: MEM→ADDL with pc_inc.
  - step 2: MEM→ADDH with pc_inc.
  - step 3: MEM→ACC with addr_sel=1 and end.
- R6: Load indexed (0x12). The steps match R5, except that step 3 uses addr_sel=2.
- R7: Add with carry immediate (0x20). ALU command codes are: none 0, add 1, increment 2, subtract 3.
  - step 1: MEM→B with pc_inc.
  - step 2: ACC→ALU with alu_cmd=1.
  - step 3: ALU→ACC with end.
- R8: Increment accumulator (0x21):
  - step 1: ACC→ALU with alu_cmd=2.
  - step 2: ALU→ACC with end.
- R9: Compare immediate (0x22):
  - step 1: MEM→B with pc_inc.
  - step 2: ACC→ALU with alu_cmd=3, cmp_en=1 and end.
- R10: Clear carry (0x40) and set carry (0x41). Step 1 is NONE→NONE with carry_clr, or with carry_set, plus end. The two carry outputs are never high together.
- R11: Push accumulator (0x50) and pop accumulator (0x51). stack_up is high only together with stack_en.
  - Push, step 1: ACC→MEM with addr_sel=3, stack_en=1, stack_up=0 and end.
  - Pop, step 1: NONE→NONE with stack_en=1 and stack_up=1.
  - Pop, step 2: MEM→ACC with addr_sel=3 and end.
- R12: Conditional jumps. Opcode 0x30 tests status[0] and opcode 0x31 tests status[1]. The status bits affect no other opcode.
  - Taken, step 1: MEM→ADDL with pc_inc.
  - Taken, step 2: MEM→ADDH with pc_inc.
  - Taken, step 3: ADDL→PCL.
  - Taken, step 4: ADDH→PCH with end.
  - Not taken, step 1: NONE→NONE with pc_inc.
  - Not taken, step 2: NONE→NONE with pc_inc and end.
- R13: An undefined opcode (for example 0x00 or 0xFF) shows NONE→NONE at step 1 with addr PC and end, and all other fields 0.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Current contents of the instruction register |
| status | input | 2 | Condition flags: bit 0 zero, bit 1 carry |
| step | output | 3 | Current microstep number |
| src_sel | output | 4 | Register code driving the internal bus |
| dst_sel | output | 4 | Register code capturing the internal bus |
| addr_sel | output | 2 | Memory address source |
| stack_en | output | 1 | Step the stack pointer |
| stack_up | output | 1 | Stack step direction, 1 is up |
| pc_inc | output | 1 | Increment the program counter |
| alu_cmd | output | 3 | ALU operation |
| carry_clr | output | 1 | Clear the carry flag |
| carry_set | output | 1 | Set the carry flag |
| cmp_en | output | 1 | Perform a compare |
| end_instr | output | 1 | Last step of the current instruction |

## Verification

The control outputs are combinational from the step register and the opcode and status inputs. A new opcode therefore shows its effect in the same cycle, and each later step appears one rising edge after the one before it. The bench drives the opcode at a falling edge while step is 0 and checks the fetch word 1 ns later. It then samples at each following falling edge, expecting step k after k rising edges, and expects step 0 on the edge after the word that carries end. After reset release, the two synchronizer edges are counted explicitly, so the first advance of the step counter is expected on the third rising edge.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  localparam int OPC_W  = 8;
  localparam int STAT_W = 2;
  localparam int STEP_W = 3;
  localparam int UADDR_W = OPC_W + STAT_W + STEP_W;

  typedef enum logic [3:0] {
    R_ACC  = 4'h0,
    R_B    = 4'h1,
    R_ALU  = 4'h2,
    R_TEMP = 4'h3,
    R_MEM  = 4'h4,
    R_IR   = 4'h5,
    R_NONE = 4'h6,
    R_PCL  = 4'h8,
    R_PCH  = 4'h9,
    R_SPL  = 4'hA,
    R_SPH  = 4'hB,
    R_ADDL = 4'hC,
    R_ADDH = 4'hD,
    R_Y    = 4'hE,
    R_X    = 4'hF
  } reg_code_t;

  typedef enum logic [1:0] {
    AS_PC  = 2'd0,
    AS_PTR = 2'd1,
    AS_XY  = 2'd2,
    AS_SP  = 2'd3
  } addr_src_t;

  typedef enum logic [2:0] {
    ALU_NOP = 3'd0,
    ALU_ADD = 3'd1,
    ALU_INC = 3'd2,
    ALU_SUB = 3'd3
  } alu_op_t;

  typedef struct packed {
    reg_code_t src;
    reg_code_t dst;
    addr_src_t asel;
    logic      stk_en;
    logic      stk_up;
    logic      pc_inc;
    alu_op_t   alu;
    logic      clc;
    logic      sec;
    logic      cmp;
    logic      done;
  } ctrl_word_t;

  localparam logic [OPC_W-1:0] OP_LD_IMM = 8'h10;
  localparam logic [OPC_W-1:0] OP_LD_ABS = 8'h11;
  localparam logic [OPC_W-1:0] OP_LD_IDX = 8'h12;
  localparam logic [OPC_W-1:0] OP_ADC    = 8'h20;
  localparam logic [OPC_W-1:0] OP_INCA   = 8'h21;
  localparam logic [OPC_W-1:0] OP_CMP    = 8'h22;
  localparam logic [OPC_W-1:0] OP_JZ     = 8'h30;
  localparam logic [OPC_W-1:0] OP_JC     = 8'h31;
  localparam logic [OPC_W-1:0] OP_CLC    = 8'h40;
  localparam logic [OPC_W-1:0] OP_SEC    = 8'h41;
  localparam logic [OPC_W-1:0] OP_PUSH   = 8'h50;
  localparam logic [OPC_W-1:0] OP_POP    = 8'h51;

  // Bus move with address source, PC increment and end flag; other fields clear.
  function automatic ctrl_word_t mk_move(reg_code_t s, reg_code_t d,
                                         addr_src_t a, logic pc, logic fin);
    ctrl_word_t w;
    w.src    = s;
    w.dst    = d;
    w.asel   = a;
    w.stk_en = 1'b0;
    w.stk_up = 1'b0;
    w.pc_inc = pc;
    w.alu    = ALU_NOP;
    w.clc    = 1'b0;
    w.sec    = 1'b0;
    w.cmp    = 1'b0;
    w.done   = fin;
    return w;
  endfunction

  localparam ctrl_word_t FETCH_WORD = '{src: R_MEM, dst: R_IR, asel: AS_PC,
                                        stk_en: 1'b0, stk_up: 1'b0, pc_inc: 1'b1,
                                        alu: ALU_NOP, clc: 1'b0, sec: 1'b0,
                                        cmp: 1'b0, done: 1'b0};

  localparam ctrl_word_t NOOP_WORD  = '{src: R_NONE, dst: R_NONE, asel: AS_PC,
                                        stk_en: 1'b0, stk_up: 1'b0, pc_inc: 1'b0,
                                        alu: ALU_NOP, clc: 1'b0, sec: 1'b0,
                                        cmp: 1'b0, done: 1'b1};

endpackage

// File: rtl/ucseq_rst_sync.sv
module ucseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ucseq_step_ctr.sv
module ucseq_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              end_instr,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d = step_q;
    if (step_en) begin
      if (end_instr) begin
        step_d = '0;
      end else begin
        step_d = step_q + STEP_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else begin
      step_q <= step_d;
    end
  end

  assign step = step_q;

endmodule

// File: rtl/ucseq_uaddr.sv
module ucseq_uaddr #(
  parameter int OPC_W  = 8,
  parameter int STAT_W = 2,
  parameter int STEP_W = 3,
  localparam int UADDR_W = OPC_W + STAT_W + STEP_W
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [STAT_W-1:0]  status,
  input  logic [STEP_W-1:0]  step,
  output logic [UADDR_W-1:0] uaddr
);

  assign uaddr = {opcode, status, step};

endmodule

// File: rtl/ucseq_urom.sv
module ucseq_urom
  import ucseq_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int STAT_W = 2,
  parameter int STEP_W = 3,
  localparam int UADDR_W = OPC_W + STAT_W + STEP_W
) (
  input  logic [UADDR_W-1:0] uaddr,
  output ctrl_word_t         word
);

  logic [OPC_W-1:0]  op;
  logic [STAT_W-1:0] st;
  logic [STEP_W-1:0] stp;
  logic              jump_taken;

  assign op  = uaddr[UADDR_W-1 -: OPC_W];
  assign st  = uaddr[STEP_W +: STAT_W];
  assign stp = uaddr[STEP_W-1:0];

  // Zero flag for one jump opcode, carry flag for the other.
  assign jump_taken = (op == OP_JZ) ? st[0] : st[1];

  always_comb begin
    word = NOOP_WORD;
    case (op)
      OP_LD_IMM: begin
        if (stp == 3'd1) word = mk_move(R_MEM, R_ACC, AS_PC, 1'b1, 1'b1);
      end
      OP_LD_ABS, OP_LD_IDX: begin
        case (stp)
          3'd1: word = mk_move(R_MEM, R_ADDL, AS_PC, 1'b1, 1'b0);
          3'd2: word = mk_move(R_MEM, R_ADDH, AS_PC, 1'b1, 1'b0);
          3'd3: word = mk_move(R_MEM, R_ACC,
                               (op == OP_LD_ABS) ? AS_PTR : AS_XY, 1'b0, 1'b1);
          default: word = NOOP_WORD;
        endcase
      end
      OP_ADC: begin
        case (stp)
          3'd1: word = mk_move(R_MEM, R_B, AS_PC, 1'b1, 1'b0);
          3'd2: begin
            word     = mk_move(R_ACC, R_ALU, AS_PC, 1'b0, 1'b0);
            word.alu = ALU_ADD;
          end
          3'd3: word = mk_move(R_ALU, R_ACC, AS_PC, 1'b0, 1'b1);
          default: word = NOOP_WORD;
        endcase
      end
      OP_INCA: begin
        case (stp)
          3'd1: begin
            word     = mk_move(R_ACC, R_ALU, AS_PC, 1'b0, 1'b0);
            word.alu = ALU_INC;
          end
          3'd2: word = mk_move(R_ALU, R_ACC, AS_PC, 1'b0, 1'b1);
          default: word = NOOP_WORD;
        endcase
      end
      OP_CMP: begin
        case (stp)
          3'd1: word = mk_move(R_MEM, R_B, AS_PC, 1'b1, 1'b0);
          3'd2: begin
            word     = mk_move(R_ACC, R_ALU, AS_PC, 1'b0, 1'b1);
            word.alu = ALU_SUB;
            word.cmp = 1'b1;
          end
          default: word = NOOP_WORD;
        endcase
      end
      OP_JZ, OP_JC: begin
        if (jump_taken) begin
          case (stp)
            3'd1: word = mk_move(R_MEM,  R_ADDL, AS_PC, 1'b1, 1'b0);
            3'd2: word = mk_move(R_MEM,  R_ADDH, AS_PC, 1'b1, 1'b0);
            3'd3: word = mk_move(R_ADDL, R_PCL,  AS_PC, 1'b0, 1'b0);
            3'd4: word = mk_move(R_ADDH, R_PCH,  AS_PC, 1'b0, 1'b1);
            default: word = NOOP_WORD;
          endcase
        end else begin
          case (stp)
            3'd1: word = mk_move(R_NONE, R_NONE, AS_PC, 1'b1, 1'b0);
            3'd2: word = mk_move(R_NONE, R_NONE, AS_PC, 1'b1, 1'b1);
            default: word = NOOP_WORD;
          endcase
        end
      end
      OP_CLC, OP_SEC: begin
        if (stp == 3'd1) begin
          word     = mk_move(R_NONE, R_NONE, AS_PC, 1'b0, 1'b1);
          word.clc = (op == OP_CLC);
          word.sec = (op == OP_SEC);
        end
      end
      OP_PUSH: begin
        if (stp == 3'd1) begin
          word        = mk_move(R_ACC, R_MEM, AS_SP, 1'b0, 1'b1);
          word.stk_en = 1'b1;
          word.stk_up = 1'b0;
        end
      end
      OP_POP: begin
        case (stp)
          3'd1: begin
            word        = mk_move(R_NONE, R_NONE, AS_PC, 1'b0, 1'b0);
            word.stk_en = 1'b1;
            word.stk_up = 1'b1;
          end
          3'd2: word = mk_move(R_MEM, R_ACC, AS_SP, 1'b0, 1'b1);
          default: word = NOOP_WORD;
        endcase
      end
      default: word = NOOP_WORD;
    endcase
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int OPC_W     = 8,
  parameter int STAT_W    = 2,
  parameter int STEP_W    = 3,
  parameter int RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [STAT_W-1:0] status,
  output logic [STEP_W-1:0] step,
  output logic [3:0]        src_sel,
  output logic [3:0]        dst_sel,
  output logic [1:0]        addr_sel,
  output logic              stack_en,
  output logic              stack_up,
  output logic              pc_inc,
  output logic [2:0]        alu_cmd,
  output logic              carry_clr,
  output logic              carry_set,
  output logic              cmp_en,
  output logic              end_instr
);

  localparam int UADDR_W = OPC_W + STAT_W + STEP_W;

  logic               core_rst_n;
  logic [STEP_W-1:0]  step_q;
  logic [UADDR_W-1:0] uaddr;
  ctrl_word_t         rom_word;
  ctrl_word_t         out_word;
  logic               at_fetch;

  ucseq_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  ucseq_step_ctr #(.STEP_W(STEP_W)) u_step_ctr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .step_en   (core_rst_n),
    .end_instr (out_word.done),
    .step      (step_q)
  );

  ucseq_uaddr #(.OPC_W(OPC_W), .STAT_W(STAT_W), .STEP_W(STEP_W)) u_uaddr (
    .opcode (opcode),
    .status (status),
    .step   (step_q),
    .uaddr  (uaddr)
  );

  ucseq_urom #(.OPC_W(OPC_W), .STAT_W(STAT_W), .STEP_W(STEP_W)) u_urom (
    .uaddr (uaddr),
    .word  (rom_word)
  );

  // The opcode register is refilled during step 0, so the fetch word is forced there.
  assign at_fetch = (step_q == '0);

  always_comb begin
    if (at_fetch) begin
      out_word = FETCH_WORD;
    end else begin
      out_word = rom_word;
    end
  end

  assign step      = step_q;
  assign src_sel   = out_word.src;
  assign dst_sel   = out_word.dst;
  assign addr_sel  = out_word.asel;
  assign stack_en  = out_word.stk_en;
  assign stack_up  = out_word.stk_up;
  assign pc_inc    = out_word.pc_inc;
  assign alu_cmd   = out_word.alu;
  assign carry_clr = out_word.clc;
  assign carry_set = out_word.sec;
  assign cmp_en    = out_word.cmp;
  assign end_instr = out_word.done;

endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] opcode,
  input logic [2:0] step,
  input logic [3:0] src_sel,
  input logic [3:0] dst_sel,
  input logic [1:0] addr_sel,
  input logic       stack_en,
  input logic       stack_up,
  input logic       pc_inc,
  input logic [2:0] alu_cmd,
  input logic       carry_clr,
  input logic       carry_set,
  input logic       cmp_en,
  input logic       end_instr
);

  // R2
  step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_instr |=> (step == 3'd0));

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !end_instr |=> (step == $past(step) + 3'd1));

  // R3
  fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd0) |-> (src_sel == 4'h4 && dst_sel == 4'h5 && addr_sel == 2'd0 &&
                        pc_inc && !end_instr && !stack_en && alu_cmd == 3'd0));

  // R10
  carry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_clr && carry_set));

  // R11
  stack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_up |-> stack_en);

  // R9
  cmp_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> (alu_cmd == 3'd3));

  // R13
  undef_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd1 && opcode == 8'hFF) |-> end_instr);

endmodule

bind ucode_sequencer ucseq_chk u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .opcode    (opcode),
  .step      (step),
  .src_sel   (src_sel),
  .dst_sel   (dst_sel),
  .addr_sel  (addr_sel),
  .stack_en  (stack_en),
  .stack_up  (stack_up),
  .pc_inc    (pc_inc),
  .alu_cmd   (alu_cmd),
  .carry_clr (carry_clr),
  .carry_set (carry_set),
  .cmp_en    (cmp_en),
  .end_instr (end_instr)
);

// File: tb/ucode_sequencer_bench.sv
`timescale 1ns/1ps
module ucode_sequencer_bench;

  logic       clk;
  logic       rst_n;
  logic [7:0] opcode;
  logic [1:0] status;
  logic [2:0] step;
  logic [3:0] src_sel, dst_sel;
  logic [1:0] addr_sel;
  logic       stack_en, stack_up, pc_inc;
  logic [2:0] alu_cmd;
  logic       carry_clr, carry_set, cmp_en, end_instr;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [19:0] exp_w [1:7];
  int          exp_n;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .status(status), .step(step),
    .src_sel(src_sel), .dst_sel(dst_sel), .addr_sel(addr_sel),
    .stack_en(stack_en), .stack_up(stack_up), .pc_inc(pc_inc),
    .alu_cmd(alu_cmd), .carry_clr(carry_clr), .carry_set(carry_set),
    .cmp_en(cmp_en), .end_instr(end_instr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [19:0] obs_w;
  assign obs_w = {src_sel, dst_sel, addr_sel, stack_en, stack_up, pc_inc,
                  alu_cmd, carry_clr, carry_set, cmp_en, end_instr};

  function automatic logic [19:0] mkw(logic [3:0] s, logic [3:0] d, logic [1:0] a,
                                      logic se, logic su, logic pc, logic [2:0] al,
                                      logic cc, logic cs, logic cm, logic dn);
    return {s, d, a, se, su, pc, al, cc, cs, cm, dn};
  endfunction

  function automatic logic [19:0] mv(logic [3:0] s, logic [3:0] d, logic [1:0] a,
                                     logic pc, logic dn);
    return mkw(s, d, a, 1'b0, 1'b0, pc, 3'd0, 1'b0, 1'b0, 1'b0, dn);
  endfunction

  localparam logic [3:0] ACC = 4'h0, B = 4'h1, ALU = 4'h2, MEM = 4'h4, IR = 4'h5,
                         NONE = 4'h6, PCL = 4'h8, PCH = 4'h9, ADDL = 4'hC, ADDH = 4'hD;

  logic [19:0] fetch_w;
  logic [19:0] noop_w;
  initial begin
    fetch_w = mv(MEM, IR, 2'd0, 1'b1, 1'b0);
    noop_w  = mv(NONE, NONE, 2'd0, 1'b0, 1'b1);
  end

  task automatic chk(string req, string what, logic [22:0] act, logic [22:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Runs one instruction from its fetch step and checks every step.
  task automatic run_seq(string req, string name, logic [7:0] op, logic [1:0] st);
    while (step !== 3'd0) @(negedge clk);
    opcode = op;
    status = st;
    #1;
    chk("R3", {name, " fetch"}, {step, obs_w}, {3'd0, fetch_w});
    for (int k = 1; k <= exp_n; k++) begin
      @(negedge clk);
      chk(req, $sformatf("%s step %0d", name, k), {step, obs_w}, {k[2:0], exp_w[k]});
    end
    @(negedge clk);
    chk("R2", {name, " return to step 0"}, {step, obs_w}, {3'd0, fetch_w});
  endtask

  task automatic t_reset;
    rst_n  = 1'b0;
    opcode = 8'hFF;
    status = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1", "in reset", {step, obs_w}, {3'd0, fetch_w});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first edge after release", {step, obs_w}, {3'd0, fetch_w});
    @(negedge clk);
    chk("R1", "second edge after release", {step, obs_w}, {3'd0, fetch_w});
    @(negedge clk);
    chk("R1", "third edge after release", {step, obs_w}, {3'd1, noop_w});
    @(negedge clk);
    chk("R2", "undefined opcode wraps", {step, obs_w}, {3'd0, fetch_w});
  endtask

  task automatic t_ld_imm;
    exp_n = 1;
    exp_w[1] = mv(MEM, ACC, 2'd0, 1'b1, 1'b1);
    run_seq("R4", "load imm", 8'h10, 2'b00);
    // R12: status bits change nothing for a non-jump opcode
    run_seq("R12", "load imm status 11", 8'h10, 2'b11);
  endtask

  task automatic t_ld_abs;
    exp_n = 3;
    exp_w[1] = mv(MEM, ADDL, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mv(MEM, ADDH, 2'd0, 1'b1, 1'b0);
    exp_w[3] = mv(MEM, ACC, 2'd1, 1'b0, 1'b1);
    run_seq("R5", "load abs", 8'h11, 2'b01);
  endtask

  task automatic t_ld_idx;
    exp_n = 3;
    exp_w[1] = mv(MEM, ADDL, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mv(MEM, ADDH, 2'd0, 1'b1, 1'b0);
    exp_w[3] = mv(MEM, ACC, 2'd2, 1'b0, 1'b1);
    run_seq("R6", "load idx", 8'h12, 2'b10);
  endtask

  task automatic t_adc;
    exp_n = 3;
    exp_w[1] = mv(MEM, B, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mkw(ACC, ALU, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_w[3] = mv(ALU, ACC, 2'd0, 1'b0, 1'b1);
    run_seq("R7", "adc imm", 8'h20, 2'b00);
  endtask

  task automatic t_inc;
    exp_n = 2;
    exp_w[1] = mkw(ACC, ALU, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_w[2] = mv(ALU, ACC, 2'd0, 1'b0, 1'b1);
    run_seq("R8", "inc acc", 8'h21, 2'b11);
  endtask

  task automatic t_cmp;
    exp_n = 2;
    exp_w[1] = mv(MEM, B, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mkw(ACC, ALU, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    run_seq("R9", "cmp imm", 8'h22, 2'b00);
  endtask

  task automatic t_carry;
    exp_n = 1;
    exp_w[1] = mkw(NONE, NONE, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_seq("R10", "clear carry", 8'h40, 2'b00);
    exp_w[1] = mkw(NONE, NONE, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    run_seq("R10", "set carry", 8'h41, 2'b00);
  endtask

  task automatic t_stack;
    exp_n = 1;
    exp_w[1] = mkw(ACC, MEM, 2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_seq("R11", "push", 8'h50, 2'b00);
    exp_n = 2;
    exp_w[1] = mkw(NONE, NONE, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_w[2] = mv(MEM, ACC, 2'd3, 1'b0, 1'b1);
    run_seq("R11", "pop", 8'h51, 2'b00);
  endtask

  task automatic t_jump;
    exp_n = 4;
    exp_w[1] = mv(MEM, ADDL, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mv(MEM, ADDH, 2'd0, 1'b1, 1'b0);
    exp_w[3] = mv(ADDL, PCL, 2'd0, 1'b0, 1'b0);
    exp_w[4] = mv(ADDH, PCH, 2'd0, 1'b0, 1'b1);
    run_seq("R12", "jz taken", 8'h30, 2'b01);
    run_seq("R12", "jc taken", 8'h31, 2'b10);
    exp_n = 2;
    exp_w[1] = mv(NONE, NONE, 2'd0, 1'b1, 1'b0);
    exp_w[2] = mv(NONE, NONE, 2'd0, 1'b1, 1'b1);
    run_seq("R12", "jz not taken", 8'h30, 2'b10);
    run_seq("R12", "jc not taken", 8'h31, 2'b01);
  endtask

  task automatic t_undef;
    exp_n = 1;
    exp_w[1] = noop_w;
    run_seq("R13", "undefined 00", 8'h00, 2'b00);
    run_seq("R13", "undefined ff", 8'hFF, 2'b11);
  endtask

  initial begin
    t_reset();
    t_ld_imm();
    t_ld_abs();
    t_ld_idx();
    t_adc();
    t_inc();
    t_cmp();
    t_carry();
    t_stack();
    t_jump();
    t_undef();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog: actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule